// File: doc/BRIEF.md
# Fractional Oversampling Baud Generator

This block derives the timing pulses that an asynchronous serial transmitter and receiver need from the peripheral clock. A programmed divider holds an integer mantissa and a fractional part. A phase accumulator adds the fraction once per sample period. Whenever it wraps, the next period is stretched by one clock. The long-run sample rate is therefore the clock divided by the exact fractional divider, with no rounding.

A mode input chooses 16 or 8 samples per bit. In the 8x mode the fraction is counted in eighths, so its top bit is ignored. The block emits a one-cycle sample tick, a bit-boundary tick for the transmitter, a mid-bit strobe for the receiver, and the index of the current sample within the bit. The resulting bit rate is `f_clk / (8 * (2 - os_half) * DIV)`, where DIV = mantissa + fraction/16 in 16x mode and mantissa + fraction/8 in 8x mode.

The divider is loaded through a plain write strobe that is accepted on every cycle; it has no back-pressure. A load restarts all phase state. So does dropping the enable or changing the oversampling mode.

Top module: `baud_gen_frac`

## Requirements
- R1: After reset, `sample_tick`, `bit_tick` and `mid_tick` are 0 and `sample_idx` is 0. The divider resets to zero, which keeps the block idle until the divider is loaded.
- R2: Let the restart edge be the clock edge that samples a write, an enable rise or a mode change, and count cycles from 0 after it. With a nonzero mantissa M, the k-th sample tick (k = 1, 2, ...) is high for exactly one cycle, at cycle k*M + floor((k-1)*F/N) - 1. N is 16 in 16x mode and 8 in 8x mode. F is the effective fraction.
- R3: The written word `cfg_wdata` holds the mantissa in bits [15:4] and the fraction in bits [3:0]. When `os_half` = 1 (8x), only fraction bits [2:0] count, and bit 3 has no effect on any output. When `os_half` = 0 (16x), all four fraction bits count.
- R4: `bit_tick` is high only together with a sample tick, and only on every N-th sample tick after the restart (k = N, 2N, ...).
- R5: The distance between two consecutive `bit_tick` pulses is exactly N*M + F clocks.
- R6: On the k-th sample tick, `sample_idx` equals (k-1) mod N. `mid_tick` is high only on sample ticks whose index is N/2, that is index 8 in 16x mode and index 4 in 8x mode.
- R7: A mantissa of zero produces no ticks of any kind, whatever the fraction.
- R8: While `enable` is 0, no ticks are produced, starting from the cycle after the edge that samples it low. When `enable` rises, the schedule restarts as in R2.
- R9: A write while running, or a change of `os_half`, discards the current phase, sample index and accumulator. The schedule of R2 restarts from that edge with the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Generator enable; low clears all phase state |
| os_half | input | 1 | 0 selects 16 samples per bit, 1 selects 8 |
| cfg_we | input | 1 | Divider write strobe, accepted every cycle |
| cfg_wdata | input | 16 | Divider word: mantissa [15:4], fraction [3:0] |
| sample_tick | output | 1 | One-cycle oversampling pulse |
| bit_tick | output | 1 | Pulse on the last sample of each bit |
| mid_tick | output | 1 | Pulse on the mid-bit sample |
| sample_idx | output | 4 | Index of the current sample within the bit |

## Verification
The hardest case to reach is a stretched period: a cycle in which the accumulator has just wrapped. Its timing depends on the whole history of fraction additions since the restart, and in 8x mode it also depends on the masking of fraction bit 3. The bench sweeps every fraction value in both modes across several small mantissas, including a mantissa of 1, where stretched and plain periods alternate closely. It compares each cycle against the closed-form tick times. Restarts are produced in the middle of a period by a write, by an enable toggle and by a mode flip, so that leftover accumulator state would show up as a shifted tick.

// File: rtl/baud_frac_pkg.sv
package baud_frac_pkg;

  typedef enum logic {
    OVS_16 = 1'b0,
    OVS_8  = 1'b1
  } ovs_e;

  // Samples per bit for a given oversampling choice and fraction width.
  function automatic int unsigned samples_per_bit(ovs_e mode, int unsigned frac_w);
    return (mode == OVS_8) ? (1 << (frac_w - 1)) : (1 << frac_w);
  endfunction

endpackage

// File: rtl/baud_cfg.sv
module baud_cfg
  import baud_frac_pkg::*;
#(
  parameter int unsigned MANT_W = 12,
  parameter int unsigned FRAC_W = 4,
  localparam int unsigned DIV_W = MANT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              os_half,
  input  logic              cfg_we,
  input  logic [DIV_W-1:0]  cfg_wdata,
  output logic [MANT_W-1:0] mant,
  output logic [FRAC_W-1:0] frac,
  output ovs_e              mode,
  output logic              run,
  output logic              clr
);

  logic [DIV_W-1:0] div_q;
  logic             en_q;
  ovs_e             mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      en_q   <= 1'b0;
      mode_q <= OVS_16;
    end else begin
      en_q   <= enable;
      mode_q <= ovs_e'(os_half);
      if (cfg_we) div_q <= cfg_wdata;
    end
  end

  assign mant = div_q[DIV_W-1:FRAC_W];
  assign frac = div_q[FRAC_W-1:0];
  assign mode = mode_q;
  assign run  = en_q && (mant != '0);
  assign clr  = cfg_we || !enable || (ovs_e'(os_half) != mode_q);

endmodule

// File: rtl/baud_pacer.sv
module baud_pacer
  import baud_frac_pkg::*;
#(
  parameter int unsigned MANT_W = 12,
  parameter int unsigned FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic [MANT_W-1:0] mant,
  input  logic [FRAC_W-1:0] frac,
  input  ovs_e              mode,
  output logic              tick
);

  localparam int unsigned CNT_W = MANT_W + 1;
  localparam int unsigned SUM_W = FRAC_W + 1;
  localparam logic [FRAC_W-1:0] LO_MASK = FRAC_W'((1 << (FRAC_W - 1)) - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  limit;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W-1:0] acc_nx;
  logic [FRAC_W-1:0] frac_eff;
  logic [SUM_W-1:0]  sum;
  logic              extra_q;
  logic              carry;

  // The fraction unit is 1/16 or 1/8 of a clock depending on mode.
  always_comb begin
    frac_eff = (mode == OVS_8) ? (frac & LO_MASK) : frac;
    sum      = {1'b0, acc_q} + {1'b0, frac_eff};
    if (mode == OVS_8) begin
      carry  = sum[FRAC_W-1];
      acc_nx = sum[FRAC_W-1:0] & LO_MASK;
    end else begin
      carry  = sum[FRAC_W];
      acc_nx = sum[FRAC_W-1:0];
    end
  end

  assign limit = {1'b0, mant} - CNT_W'(1) + CNT_W'(extra_q);
  assign tick  = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      extra_q <= 1'b0;
    end else if (clr) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      extra_q <= 1'b0;
    end else if (tick) begin
      cnt_q   <= '0;
      acc_q   <= acc_nx;
      extra_q <= carry;
    end else if (run) begin
      cnt_q   <= cnt_q + CNT_W'(1);
    end
  end

  // R2: a period is at least two clocks when the mantissa exceeds one
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && mant > MANT_W'(1)) |=> !tick);

  // R9: a restart leaves the period counter and accumulator empty
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && acc_q == '0 && !extra_q));

endmodule

// File: rtl/baud_bit_phase.sv
module baud_bit_phase
  import baud_frac_pkg::*;
#(
  parameter int unsigned FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  ovs_e              mode,
  output logic [FRAC_W-1:0] idx,
  output logic              bit_tick,
  output logic              mid_tick
);

  localparam int unsigned SPB_HI = samples_per_bit(OVS_16, FRAC_W);
  localparam int unsigned SPB_LO = samples_per_bit(OVS_8, FRAC_W);
  localparam logic [FRAC_W-1:0] LAST_HI = FRAC_W'(SPB_HI - 1);
  localparam logic [FRAC_W-1:0] LAST_LO = FRAC_W'(SPB_LO - 1);
  localparam logic [FRAC_W-1:0] MID_HI  = FRAC_W'(SPB_HI / 2);
  localparam logic [FRAC_W-1:0] MID_LO  = FRAC_W'(SPB_LO / 2);

  logic [FRAC_W-1:0] idx_q;
  logic [FRAC_W-1:0] last;
  logic [FRAC_W-1:0] mid;

  assign last = (mode == OVS_8) ? LAST_LO : LAST_HI;
  assign mid  = (mode == OVS_8) ? MID_LO  : MID_HI;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (clr)    idx_q <= '0;
    else if (tick)   idx_q <= (idx_q == last) ? '0 : idx_q + FRAC_W'(1);
  end

  assign idx      = idx_q;
  assign bit_tick = tick && (idx_q == last);
  assign mid_tick = tick && (idx_q == mid);

  // R6: the sample index never leaves the range of the selected mode
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= last);

  // R9: a restart returns the sample index to zero
  idx_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> idx_q == '0);

endmodule

// File: rtl/baud_gen_frac.sv
module baud_gen_frac
  import baud_frac_pkg::*;
#(
  parameter int unsigned MANT_W = 12,
  parameter int unsigned FRAC_W = 4,
  localparam int unsigned DIV_W = MANT_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              os_half,
  input  logic              cfg_we,
  input  logic [DIV_W-1:0]  cfg_wdata,
  output logic              sample_tick,
  output logic              bit_tick,
  output logic              mid_tick,
  output logic [FRAC_W-1:0] sample_idx
);

  logic [MANT_W-1:0] mant_w;
  logic [FRAC_W-1:0] frac_w;
  ovs_e              mode_w;
  logic              run_w;
  logic              clr_w;

  baud_cfg #(.MANT_W(MANT_W), .FRAC_W(FRAC_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .os_half   (os_half),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .mant      (mant_w),
    .frac      (frac_w),
    .mode      (mode_w),
    .run       (run_w),
    .clr       (clr_w)
  );

  baud_pacer #(.MANT_W(MANT_W), .FRAC_W(FRAC_W)) u_pacer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_w),
    .clr   (clr_w),
    .mant  (mant_w),
    .frac  (frac_w),
    .mode  (mode_w),
    .tick  (sample_tick)
  );

  baud_bit_phase #(.FRAC_W(FRAC_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_w),
    .tick     (sample_tick),
    .mode     (mode_w),
    .idx      (sample_idx),
    .bit_tick (bit_tick),
    .mid_tick (mid_tick)
  );

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mant_w == '0) |-> !sample_tick);

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !sample_tick);

  // R4
  bit_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick || mid_tick) |-> sample_tick);

endmodule

// File: tb/sim_baud_gen_frac.sv
module sim_baud_gen_frac;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        os_half = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        sample_tick, bit_tick, mid_tick;
  logic [3:0]  sample_idx;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  baud_gen_frac u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .os_half(os_half),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .sample_tick(sample_tick), .bit_tick(bit_tick),
    .mid_tick(mid_tick), .sample_idx(sample_idx)
  );

  function automatic int t_of(int k, int m, int fe, int n);
    return k * m + ((k - 1) * fe) / n;
  endfunction

  // Load a divider; returns in cycle 0 after the restart edge.
  task automatic load(int m, int f, int h);
    @(posedge clk); #1;
    cfg_we    = 1'b1;
    cfg_wdata = {m[11:0], f[3:0]};
    os_half   = h[0];
    enable    = 1'b1;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    #1;
  endtask

  // Follow nt sample ticks from cycle 0 and compare against R2..R6.
  task automatic follow(int m, int f, int h, int nt, string tag);
    int n, fe, k, bad, sp_bad, sp_seen, last_bit;
    bit et, eb, em;
    int ei;
    n = h ? 8 : 16;
    fe = h ? (f & 7) : f;
    k = 1; bad = 0; sp_bad = 0; sp_seen = 0; last_bit = -1;
    for (int c = 0; k <= nt; c++) begin
      et = (c + 1 == t_of(k, m, fe, n));
      eb = et && (k % n == 0);
      em = et && ((k - 1) % n == n / 2);
      ei = (k - 1) % n;
      if (sample_tick !== et || bit_tick !== eb || mid_tick !== em ||
          (et && sample_idx !== 4'(ei))) begin
        if (bad == 0)
          $display("FAIL %s m=%0d f=%0d h=%0d cycle %0d: tick/bit/mid/idx=%b%b%b/%0d expected %b%b%b/%0d",
                   tag, m, f, h, c, sample_tick, bit_tick, mid_tick, sample_idx, et, eb, em, ei);
        bad++;
      end
      if (eb && bit_tick === 1'b1) begin
        if (last_bit >= 0) begin
          sp_seen++;
          if (c - last_bit != n * m + fe) begin
            if (sp_bad == 0)
              $display("FAIL R5 m=%0d f=%0d h=%0d: bit spacing %0d expected %0d",
                       m, f, h, c - last_bit, n * m + fe);
            sp_bad++;
          end
        end
        last_bit = c;
      end
      if (et) k++;
      @(posedge clk); #2;
    end
    tests++;
    if (bad != 0) fails++;
    if (sp_seen != 0) begin
      tests++;
      if (sp_bad != 0) fails++;
    end
  endtask

  task automatic quiet(int cycles, string tag);
    int seen;
    seen = 0;
    for (int c = 0; c < cycles; c++) begin
      if (sample_tick || bit_tick || mid_tick) seen++;
      @(posedge clk); #2;
    end
    tests++;
    if (seen != 0) begin
      fails++;
      $display("FAIL %s: %0d tick cycles, expected 0", tag, seen);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1: reset state
    tests++;
    if (sample_tick || bit_tick || mid_tick || sample_idx != 0) begin
      fails++;
      $display("FAIL R1: outputs %b%b%b idx %0d expected 000 idx 0",
               sample_tick, bit_tick, mid_tick, sample_idx);
    end

    // R7: zero mantissa stays idle
    load(0, 5, 0);
    quiet(200, "R7");
    load(0, 15, 1);
    quiet(100, "R7");

    // R2 R3 R4 R5 R6: sweep of mantissas, all fractions, both modes
    for (int h = 0; h < 2; h++)
      for (int mi = 0; mi < 4; mi++)
        for (int f = 0; f < 16; f++) begin
          int m;
          m = (mi == 0) ? 1 : (mi == 1) ? 2 : (mi == 2) ? 3 : 7;
          load(m, f, h);
          follow(m, f, h, (h ? 16 : 32) + 3, h ? "R3" : "R2");
        end

    // R2: larger mantissa
    load(300, 7, 0);
    follow(300, 7, 0, 3, "R2");

    // R8: enable low silences ticks, rise restarts the schedule
    load(3, 5, 0);
    follow(3, 5, 0, 7, "R8");
    @(posedge clk); #1 enable = 1'b0;
    @(posedge clk); #1;
    quiet(60, "R8");
    @(posedge clk); #1 enable = 1'b1;
    @(posedge clk); #2;
    follow(3, 5, 0, 40, "R8");

    // R9: write while running restarts from the write edge
    load(2, 3, 0);
    follow(2, 3, 0, 5, "R9");
    load(5, 9, 0);
    follow(5, 9, 0, 36, "R9");

    // R9: mode change restarts and applies the new fraction unit
    load(4, 14, 0);
    follow(4, 14, 0, 5, "R9");
    @(posedge clk); #1 os_half = 1'b1;
    @(posedge clk); #2;
    follow(4, 14, 1, 20, "R9");

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule